// File: doc/BRIEF.md
# Interrupt Request Flag Bank

This block keeps one pending bit for each interrupt source and hands the full set to a downstream priority and mask stage. Hardware sources raise their bits with single-cycle request pulses. The interrupt controller clears a bit by returning the source index on an acknowledge strobe. Software can inspect and change the bits over a small register bus.

The 22 flags live in three 8-bit registers at offsets 0, 1 and 2. Offsets 0 and 1 are fully populated. Offset 2 carries flags only in bits 7..2. Software may replace a whole register with a byte write. It may replace offsets 0 and 1 together with a 16-bit word write. It may also set or clear one bit without touching its neighbours. Because the bit operations change nothing else, software can clear a handled flag without risking loss of a request that lands on another bit of the same register.

The reset input is active low. It asserts asynchronously and is expected to be released in step with the clock.

Top module: `intr_pend_bank`

## Requirements
- R1: While reset is asserted and after it is released, every flag is 0, so `pend_o` is 0 and every read returns 0.
- R2: A pulse on `req_i[s]` makes the flag of source s read 1 from the next clock edge. Sources 0..15 map to offset s/8, bit s%8. Sources 16..21 map to offset 2, bit s-14.
- R3: With `ack_vld_i` high and `ack_idx_i` = s, where s < 22, the flag of source s is 0 after the edge. This holds even if software sets it in the same cycle. Index values 22..31 change nothing.
- R4: A write with `bus_op_i` = 2'b00 (byte), `bus_en_i` and `bus_we_i` high, and `bus_addr_i` in 0..2 replaces the implemented bits of that register with `bus_wdata_i[7:0]`.
- R5: A write with `bus_op_i` = 2'b01 (word) at offset 0 loads `bus_wdata_i[7:0]` into offset 0 and `bus_wdata_i[15:8]` into offset 1. A word write at any other offset changes nothing.
- R6: `bus_op_i` = 2'b10 (bit set) or 2'b11 (bit clear), issued as a write, forces 1 or 0 into the bit that `bus_addr_i` and `bus_bit_i` select. Every other flag keeps its value.
- R7: When a request and a software write or bit clear hit the same flag in one cycle, the flag ends at 1.
- R8: When a request and an acknowledge hit the same flag in one cycle, the flag ends at 1.
- R9: Offset 2 bits 1..0 and all of offset 3 always read 0. Byte, bit-set and bit-clear writes aimed at them have no effect.
- R10: `bus_rdata_o` is combinational and has no side effects. A byte read returns {8'h00, register}. A word read at offset 0 returns {offset 1, offset 0}. A word read elsewhere returns 0.
- R11: `pend_o` shows the three registers side by side: offset r occupies bits 8r+7..8r, and the unimplemented bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 22 | One request pulse per source |
| ack_vld_i | input | 1 | Acknowledge strobe |
| ack_idx_i | input | 5 | Index of the acknowledged source |
| bus_en_i | input | 1 | Bus access valid |
| bus_we_i | input | 1 | 1 = write/set/clear, 0 = read |
| bus_op_i | input | 2 | 00 byte, 01 word, 10 bit set, 11 bit clear |
| bus_addr_i | input | 2 | Register offset |
| bus_bit_i | input | 3 | Bit index for bit set/clear |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data |
| pend_o | output | 24 | Flag image for the priority stage |

## Verification
The bound checker watches several rules on every cycle:
- a request always leaves its flag set, and an acknowledge without a competing request always leaves it clear;
- a bit clear without a request leaves its bit at 0;
- unimplemented positions never read 1;
- the image holds still whenever no request, acknowledge or write is present.

Some behaviour only the bench scenarios can show, because it is checked against a reference model of the register image:
- how byte and word writes merge data across the register boundary;
- the exact read data for every op and offset;
- the order in which same-cycle races resolve across software and hardware paths.

// File: rtl/intr_pend_pkg.sv
package intr_pend_pkg;

  typedef enum logic [1:0] {
    OP_BYTE = 2'b00,
    OP_WORD = 2'b01,
    OP_BSET = 2'b10,
    OP_BCLR = 2'b11
  } bus_op_e;

  // number of set bits of mask strictly below position p
  function automatic int cnt_below(input logic [63:0] mask, input int p);
    int n;
    n = 0;
    for (int i = 0; i < 64; i++) if (i < p && mask[i]) n++;
    return n;
  endfunction

  // flat position of the s-th implemented bit
  function automatic int pos_of_src(input logic [63:0] mask, input int s);
    int n;
    int r;
    n = 0;
    r = 0;
    for (int i = 0; i < 64; i++) begin
      if (mask[i]) begin
        if (n == s) r = i;
        n++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/intr_pend_decode.sv
module intr_pend_decode
  import intr_pend_pkg::*;
#(
  parameter int NUM_REGS  = 3,
  parameter int REG_W     = 8,
  parameter int WORD_REGS = 2,
  parameter int ADDR_W    = 2,
  parameter logic [NUM_REGS*REG_W-1:0] IMPL_MASK = 24'hFC_FFFF,
  localparam int TOT_W   = NUM_REGS * REG_W,
  localparam int WORD_W  = WORD_REGS * REG_W,
  localparam int BIT_W   = $clog2(REG_W),
  localparam int NUM_SRC = cnt_below(64'(IMPL_MASK), TOT_W)
) (
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_op_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BIT_W-1:0]  bus_bit_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [NUM_SRC-1:0] sw_we_o,
  output logic [NUM_SRC-1:0] sw_val_o
);

  logic wr_act;
  logic op_byte, op_word, op_bit, op_set;

  always_comb begin
    wr_act  = bus_en_i && bus_we_i;
    op_byte = wr_act && (bus_op_i == OP_BYTE);
    op_word = wr_act && (bus_op_i == OP_WORD) && (bus_addr_i == '0);
    op_bit  = wr_act && ((bus_op_i == OP_BSET) || (bus_op_i == OP_BCLR));
    op_set  = (bus_op_i == OP_BSET);
  end

  for (genvar p = 0; p < TOT_W; p++) begin : g_pos
    if (IMPL_MASK[p]) begin : g_impl
      localparam int S  = cnt_below(64'(IMPL_MASK), p);
      localparam int RG = p / REG_W;
      localparam int BT = p % REG_W;
      logic hit_reg, sel_byte, sel_bit, sel_word, word_bit;
      always_comb begin
        hit_reg  = (bus_addr_i == ADDR_W'(RG));
        sel_byte = op_byte && hit_reg;
        sel_bit  = op_bit && hit_reg && (bus_bit_i == BIT_W'(BT));
      end
      if (RG < WORD_REGS) begin : g_word
        always_comb begin
          sel_word = op_word;
          word_bit = bus_wdata_i[p];
        end
      end else begin : g_noword
        always_comb begin
          sel_word = 1'b0;
          word_bit = 1'b0;
        end
      end
      always_comb begin
        sw_we_o[S]  = sel_byte || sel_word || sel_bit;
        sw_val_o[S] = sel_bit  ? op_set :
                      sel_word ? word_bit : bus_wdata_i[BT];
      end
    end
  end

endmodule

// File: rtl/intr_pend_cell.sv
module intr_pend_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic ack_i,
  input  logic sw_we_i,
  input  logic sw_val_i,
  output logic flag_o
);

  logic flag_q, flag_d, flag_en;

  // request beats acknowledge and software; acknowledge beats software
  always_comb begin
    flag_en = req_i || ack_i || sw_we_i;
    flag_d  = req_i || (!ack_i && sw_we_i && sw_val_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/intr_pend_rdmux.sv
module intr_pend_rdmux
  import intr_pend_pkg::*;
#(
  parameter int NUM_REGS  = 3,
  parameter int REG_W     = 8,
  parameter int WORD_REGS = 2,
  parameter int ADDR_W    = 2,
  localparam int TOT_W  = NUM_REGS * REG_W,
  localparam int WORD_W = WORD_REGS * REG_W
) (
  input  logic [TOT_W-1:0]  flags_i,
  input  logic [1:0]        bus_op_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic [WORD_W-1:0] bus_rdata_o
);

  always_comb begin
    bus_rdata_o = '0;
    if (bus_op_i == OP_WORD) begin
      if (bus_addr_i == '0) bus_rdata_o = flags_i[WORD_W-1:0];
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (bus_addr_i == ADDR_W'(r)) bus_rdata_o[REG_W-1:0] = flags_i[r*REG_W +: REG_W];
      end
    end
  end

endmodule

// File: rtl/intr_pend_bank.sv
module intr_pend_bank
  import intr_pend_pkg::*;
#(
  parameter int NUM_REGS  = 3,
  parameter int REG_W     = 8,
  parameter int WORD_REGS = 2,
  parameter int ADDR_W    = 2,
  parameter logic [NUM_REGS*REG_W-1:0] IMPL_MASK = 24'hFC_FFFF,
  localparam int TOT_W   = NUM_REGS * REG_W,
  localparam int WORD_W  = WORD_REGS * REG_W,
  localparam int BIT_W   = $clog2(REG_W),
  localparam int NUM_SRC = cnt_below(64'(IMPL_MASK), TOT_W),
  localparam int ACK_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               ack_vld_i,
  input  logic [ACK_W-1:0]   ack_idx_i,
  input  logic               bus_en_i,
  input  logic               bus_we_i,
  input  logic [1:0]         bus_op_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [BIT_W-1:0]   bus_bit_i,
  input  logic [WORD_W-1:0]  bus_wdata_i,
  output logic [WORD_W-1:0]  bus_rdata_o,
  output logic [TOT_W-1:0]   pend_o
);

  logic [NUM_SRC-1:0] sw_we, sw_val, ack_hit, src_q;
  logic [TOT_W-1:0]   flags;

  intr_pend_decode #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .WORD_REGS(WORD_REGS),
    .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK)
  ) u_dec (
    .bus_en_i(bus_en_i), .bus_we_i(bus_we_i), .bus_op_i(bus_op_i),
    .bus_addr_i(bus_addr_i), .bus_bit_i(bus_bit_i), .bus_wdata_i(bus_wdata_i),
    .sw_we_o(sw_we), .sw_val_o(sw_val)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_comb ack_hit[s] = ack_vld_i && (ack_idx_i == ACK_W'(s));
    intr_pend_cell u_cell (
      .clk(clk), .rst_n(rst_n), .req_i(req_i[s]), .ack_i(ack_hit[s]),
      .sw_we_i(sw_we[s]), .sw_val_i(sw_val[s]), .flag_o(src_q[s])
    );
  end

  for (genvar p = 0; p < TOT_W; p++) begin : g_img
    if (IMPL_MASK[p]) begin : g_on
      assign flags[p] = src_q[cnt_below(64'(IMPL_MASK), p)];
    end else begin : g_off
      assign flags[p] = 1'b0;
    end
  end

  intr_pend_rdmux #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .WORD_REGS(WORD_REGS), .ADDR_W(ADDR_W)
  ) u_rd (
    .flags_i(flags), .bus_op_i(bus_op_i), .bus_addr_i(bus_addr_i),
    .bus_rdata_o(bus_rdata_o)
  );

  assign pend_o = flags;

endmodule

// File: rtl/intr_pend_bank_chk.sv
module intr_pend_bank_chk
  import intr_pend_pkg::*;
#(
  parameter int NUM_REGS  = 3,
  parameter int REG_W     = 8,
  parameter int ADDR_W    = 2,
  parameter logic [NUM_REGS*REG_W-1:0] IMPL_MASK = 24'hFC_FFFF,
  localparam int TOT_W   = NUM_REGS * REG_W,
  localparam int BIT_W   = $clog2(REG_W),
  localparam int NUM_SRC = cnt_below(64'(IMPL_MASK), TOT_W),
  localparam int ACK_W   = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] req_i,
  input logic               ack_vld_i,
  input logic [ACK_W-1:0]   ack_idx_i,
  input logic               bus_en_i,
  input logic               bus_we_i,
  input logic [1:0]         bus_op_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [BIT_W-1:0]   bus_bit_i,
  input logic [TOT_W-1:0]   pend_o
);

  a_r9_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o & ~IMPL_MASK) == '0);

  // R10: nothing moves the image when no writer is active
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|req_i) && !ack_vld_i && !(bus_en_i && bus_we_i)) |=> $stable(pend_o));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_s
    localparam int P = pos_of_src(64'(IMPL_MASK), s);

    a_r2_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[s] |=> pend_o[P]);

    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vld_i && ack_idx_i == ACK_W'(s) && !req_i[s]) |=> !pend_o[P]);

    a_r6_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en_i && bus_we_i && bus_op_i == OP_BCLR &&
       bus_addr_i == ADDR_W'(P / REG_W) && bus_bit_i == BIT_W'(P % REG_W) &&
       !req_i[s]) |=> !pend_o[P]);
  end

endmodule

bind intr_pend_bank intr_pend_bank_chk #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_vld_i(ack_vld_i),
  .ack_idx_i(ack_idx_i), .bus_en_i(bus_en_i), .bus_we_i(bus_we_i),
  .bus_op_i(bus_op_i), .bus_addr_i(bus_addr_i), .bus_bit_i(bus_bit_i),
  .pend_o(pend_o)
);

// File: tb/intr_pend_bank_tb_top.sv
module intr_pend_bank_tb_top;

  logic        clk, rst_n;
  logic [21:0] req;
  logic        ack_vld;
  logic [4:0]  ack_idx;
  logic        en, we;
  logic [1:0]  op, addr;
  logic [2:0]  bsel;
  logic [15:0] wdata, rdata;
  logic [23:0] pend;

  int n_chk = 0;
  int n_bad = 0;
  logic [23:0] model;

  intr_pend_bank dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ack_vld_i(ack_vld), .ack_idx_i(ack_idx),
    .bus_en_i(en), .bus_we_i(we), .bus_op_i(op), .bus_addr_i(addr),
    .bus_bit_i(bsel), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pend_o(pend)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int src_pos(int s);
    return (s < 16) ? s : s + 2;
  endfunction

  function automatic logic [23:0] mdl_next(logic [23:0] cur, logic [21:0] rq, logic av,
      logic [4:0] ai, logic e, logic w, logic [1:0] o, logic [1:0] ad, logic [2:0] bs,
      logic [15:0] wd);
    logic [23:0] n;
    n = cur;
    if (e && w) begin
      case (o)
        2'b00: if (ad < 3) n[int'(ad)*8 +: 8] = wd[7:0];
        2'b01: if (ad == 0) n[15:0] = wd;
        2'b10: if (ad < 3) n[int'(ad)*8 + int'(bs)] = 1'b1;
        default: if (ad < 3) n[int'(ad)*8 + int'(bs)] = 1'b0;
      endcase
    end
    n &= 24'hFC_FFFF;
    if (av && ai < 22) n[src_pos(int'(ai))] = 1'b0;
    for (int s = 0; s < 22; s++) if (rq[s]) n[src_pos(s)] = 1'b1;
    return n;
  endfunction

  function automatic logic [15:0] mdl_read(logic [23:0] cur, logic [1:0] o, logic [1:0] ad);
    if (o == 2'b01) return (ad == 0) ? cur[15:0] : 16'h0;
    return (ad < 3) ? {8'h00, cur[int'(ad)*8 +: 8]} : 16'h0;
  endfunction

  task automatic check(string tag, string what, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [21:0] rq, logic av, logic [4:0] ai, logic e,
      logic w, logic [1:0] o, logic [1:0] ad, logic [2:0] bs, logic [15:0] wd);
    req = rq; ack_vld = av; ack_idx = ai; en = e; we = w;
    op = o; addr = ad; bsel = bs; wdata = wd;
    #1;
    check(tag, "rdata", {8'h0, rdata}, {8'h0, mdl_read(model, o, ad)});
    @(posedge clk);
    model = mdl_next(model, rq, av, ai, e, w, o, ad, bs, wd);
    #1;
    check(tag, "pend", pend, model);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h51C3);
    rst_n = 1'b0; req = '0; ack_vld = 1'b0; ack_idx = '0; en = 1'b0; we = 1'b0;
    op = '0; addr = '0; bsel = '0; wdata = '0; model = '0;
    repeat (3) @(negedge clk);
    check("R1", "pend in reset", pend, 24'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "pend after reset", pend, 24'h0);
    check("R1", "rdata after reset", {8'h0, rdata}, 24'h0);

    // R2: requests at both ends of each register
    step("R2", 22'h000001, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2", 22'h008000, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2", 22'h010000, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2", 22'h200000, 0, 0, 0, 0, 0, 2, 0, 0);
    // R3: acknowledge clears, out-of-range index ignored
    step("R3", 0, 1, 5'd16, 0, 0, 0, 2, 0, 0);
    step("R3", 0, 1, 5'd25, 0, 0, 0, 2, 0, 0);
    step("R3", 0, 1, 5'd0, 1, 1, 2'b10, 0, 3'd0, 0);
    // R4 / R9: byte write to offset 2 keeps low bits at zero
    step("R4", 0, 0, 0, 1, 1, 2'b00, 2, 0, 16'h00FF);
    step("R9", 0, 0, 0, 1, 0, 2'b00, 2, 0, 0);
    // R5: word write and misplaced word write
    step("R5", 0, 0, 0, 1, 1, 2'b01, 0, 0, 16'hA55A);
    step("R5", 0, 0, 0, 1, 1, 2'b01, 1, 0, 16'hFFFF);
    // R9: writes to holes and offset 3
    step("R9", 0, 0, 0, 1, 1, 2'b10, 2, 3'd1, 0);
    step("R9", 0, 0, 0, 1, 1, 2'b00, 3, 0, 16'h00FF);
    step("R9", 0, 0, 0, 1, 0, 2'b00, 3, 0, 0);
    // R6: single bit clear and set
    step("R6", 0, 0, 0, 1, 1, 2'b11, 1, 3'd3, 16'hFFFF);
    step("R6", 0, 0, 0, 1, 1, 2'b10, 0, 3'd2, 0);
    // R7: request beats bit clear and byte write
    step("R7", 22'h000004, 0, 0, 1, 1, 2'b11, 0, 3'd2, 0);
    step("R7", 22'h000200, 0, 0, 1, 1, 2'b00, 1, 0, 16'h0000);
    // R8: request beats acknowledge
    step("R8", 22'h000020, 1, 5'd5, 0, 0, 0, 0, 0, 0);
    // R10: reads of every kind leave the image alone
    step("R10", 0, 0, 0, 1, 0, 2'b01, 0, 0, 16'hFFFF);
    step("R10", 0, 0, 0, 1, 0, 2'b00, 1, 0, 0);
    step("R10", 0, 0, 0, 1, 0, 2'b01, 2, 0, 0);

    // R11: constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [21:0] rq;
      logic av;
      rq = 22'($urandom & $urandom & $urandom & $urandom);
      av = ($urandom % 4) == 0;
      step("R11", rq, av, 5'($urandom), ($urandom % 3) != 0, ($urandom % 2) == 0,
           2'($urandom), 2'($urandom), 3'($urandom), 16'($urandom));
    end

    req = '0; ack_vld = 1'b0; en = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule